// File: doc/BRIEF.md
# Cubic INL Correction Evaluator

This block sits beside a high-resolution data converter and corrects that converter's integral nonlinearity on every sample. For each incoming 14-bit converter code x it evaluates a stored cubic y = b0 + b1·u + b2·u² + b3·u³ in fixed point. Here u = x / 2^14 is the code normalised into [0, 1). The block then rounds y to the nearest step of a 6-bit signed auxiliary correction converter, clamps it to that converter's range and emits it. The original code leaves on the same transfer, so the two converter inputs stay aligned.

The four signed coefficients are produced by an off-line characterisation step. That step loads them through a write port into a shadow set. A separate commit strobe copies the whole shadow set into the active set in one cycle. A sample therefore never mixes old and new coefficients. Each sample carries its own copy of the active set down the pipeline, so a commit that lands while samples are in flight leaves those samples untouched.

The datapath is a Horner pipeline with one multiply-add per stage and a final round-and-clamp stage. It accepts one code per clock when the consumer is ready and holds its output under backpressure. A sticky flag records any sample whose correction had to be clamped.

Top module: `inl_cubic_corr`

## Requirements
- R1: While reset is high and after its release, out_valid and ovf_sticky are 0 and in_ready is 1. Both coefficient sets hold all zeros, so every code first yields correction 0.
- R2: Coefficients are 18-bit two's complement with 8 fractional bits. The value is computed as acc = b3, then acc = floor(acc·x / 2^14) + bk for k = 2, 1, 0 in that order, with x unsigned.
- R3: The correction code is floor((acc + 128) / 256), which rounds to nearest with ties toward positive infinity (for example, acc = 128 gives 1 and acc = −128 gives 0).
- R4: out_corr is a 6-bit two's complement code. A rounded value above 31 is output as 31 and one below −32 is output as −32.
- R5: ovf_sticky rises when a clamped result enters the output register and stays 1 until reset. Results of exactly 31 or −32 do not set it.
- R6: out_code equals the in_code of the same sample. With out_ready held at 1, a sample accepted on a clock edge appears on out_valid after the third following rising edge.
- R7: With out_ready at 1, in_ready stays 1 every cycle, and results come out in acceptance order, one per cycle.
- R8: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_corr and out_code hold their values. No sample is lost or repeated.
- R9: cfg_we writes cfg_data into shadow coefficient cfg_sel, where 0 selects b0, 1 b1, 2 b2 and 3 b3. A write has no effect on results until a commit.
- R10: cfg_commit copies all four shadow coefficients into the active set at once. A sample accepted in the commit cycle or earlier uses the old set, and a sample accepted later uses the new set.
- R11: When cfg_we and cfg_commit are high in the same cycle, the commit copies the shadow contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Shadow coefficient write enable |
| cfg_sel | input | 2 | Shadow coefficient index (0 = b0 … 3 = b3) |
| cfg_data | input | 18 | Coefficient value, signed, 8 fractional bits |
| cfg_commit | input | 1 | Copy the shadow set into the active set |
| in_valid | input | 1 | Input code valid |
| in_ready | output | 1 | Block can accept a code this cycle |
| in_code | input | 14 | Main converter code |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Consumer accepts the output pair |
| out_code | output | 14 | Delayed main converter code |
| out_corr | output | 6 | Signed correction code for the auxiliary converter |
| ovf_sticky | output | 1 | Set once any correction was clamped |

## Verification
The evaluator is driven with one nonzero coefficient at a time to isolate each Horner term. It is also driven with full cubic sets over the end codes 0, 1, 8192 and 16383 and a pseudo-random code stream. These separate errors in term order, in the signedness of the code operand and in the truncation after each scaling. Constant-only coefficient sets placed at ±0.5, just below and just above a step show whether the rounding breaks ties the stated way. Offsets at exactly 31 and −32 and beyond them tell exact-limit results from clamped ones on the sticky flag. Commits timed inside a running stream, and writes paired with commits, show whether the active set switches at the required sample.

// File: rtl/inl_corr_pkg.sv
package inl_corr_pkg;

    localparam int unsigned DEF_CODE_W = 14;
    localparam int unsigned DEF_COEF_W = 18;
    localparam int unsigned DEF_FRAC_W = 8;
    localparam int unsigned DEF_CORR_W = 6;
    localparam int unsigned NUM_COEF   = 4;

    // Index of a coefficient on the write port.
    typedef enum logic [1:0] {
        SEL_B0 = 2'd0,
        SEL_B1 = 2'd1,
        SEL_B2 = 2'd2,
        SEL_B3 = 2'd3
    } coef_sel_e;

    // Outcome of the final range check.
    typedef enum logic [1:0] {
        CLIP_NONE = 2'd0,
        CLIP_HIGH = 2'd1,
        CLIP_LOW  = 2'd2
    } clip_e;

    // Accumulator headroom: |acc| < 4 * 2^(COEF_W-1) because |u| < 1.
    function automatic int unsigned acc_width(input int unsigned coef_w);
        return coef_w + 3;
    endfunction

endpackage

// File: rtl/inl_coef_bank.sv
module inl_coef_bank
    import inl_corr_pkg::*;
#(
    parameter int unsigned COEF_W = DEF_COEF_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [1:0]                     wr_sel,
    input  logic [COEF_W-1:0]              wr_data,
    input  logic                           commit,
    output logic [NUM_COEF-1:0][COEF_W-1:0] active
);

    logic [NUM_COEF-1:0][COEF_W-1:0] shadow;
    coef_sel_e                       sel_e;

    assign sel_e = coef_sel_e'(wr_sel);

    for (genvar k = 0; k < NUM_COEF; k++) begin : g_slot
        // Shadow slot: written by the configuration port.
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow[k] <= '0;
            end else if (wr_en && (sel_e == coef_sel_e'(k))) begin
                shadow[k] <= wr_data;
            end
        end

        // Active slot: all four update on the same edge, from the
        // shadow value held before any same-cycle write.
        always_ff @(posedge clk) begin
            if (rst) begin
                active[k] <= '0;
            end else if (commit) begin
                active[k] <= shadow[k];
            end
        end
    end

endmodule

// File: rtl/inl_horner_stage.sv
module inl_horner_stage
    import inl_corr_pkg::*;
#(
    parameter int unsigned CODE_W = DEF_CODE_W,
    parameter int unsigned COEF_W = DEF_COEF_W,
    parameter int unsigned ACC_W  = acc_width(DEF_COEF_W),
    parameter int unsigned KIDX   = 0
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            adv,
    input  logic                            in_v,
    input  logic [CODE_W-1:0]               in_code,
    input  logic signed [ACC_W-1:0]         in_acc,
    input  logic [NUM_COEF-1:0][COEF_W-1:0] in_co,
    output logic                            out_v,
    output logic [CODE_W-1:0]               out_code,
    output logic signed [ACC_W-1:0]         out_acc,
    output logic [NUM_COEF-1:0][COEF_W-1:0] out_co
);

    localparam int unsigned PROD_W = ACC_W + CODE_W + 1;
    localparam int unsigned EXT_W  = ACC_W - COEF_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic signed [ACC_W-1:0]  coef_ext;
    logic signed [ACC_W-1:0]  acc_nxt;

    always_comb begin
        // The code is an unsigned magnitude; a zero MSB keeps it positive.
        prod     = in_acc * $signed({1'b0, in_code});
        scaled   = prod >>> CODE_W;
        coef_ext = {{EXT_W{in_co[KIDX][COEF_W-1]}}, in_co[KIDX]};
        acc_nxt  = $signed(scaled[ACC_W-1:0]) + coef_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v <= 1'b0;
        end else if (adv) begin
            out_v <= in_v;
        end
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            out_code <= in_code;
            out_acc  <= acc_nxt;
            out_co   <= in_co;
        end
    end

endmodule

// File: rtl/inl_round_sat.sv
module inl_round_sat
    import inl_corr_pkg::*;
#(
    parameter int unsigned CODE_W = DEF_CODE_W,
    parameter int unsigned ACC_W  = acc_width(DEF_COEF_W),
    parameter int unsigned FRAC_W = DEF_FRAC_W,
    parameter int unsigned CORR_W = DEF_CORR_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     adv,
    input  logic                     in_v,
    input  logic [CODE_W-1:0]        in_code,
    input  logic signed [ACC_W-1:0]  in_acc,
    output logic                     out_v,
    output logic [CODE_W-1:0]        out_code,
    output logic signed [CORR_W-1:0] out_corr,
    output clip_e                    clip_o
);

    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC_W - 1);
    localparam logic signed [ACC_W-1:0] TOP  = ACC_W'((1 << (CORR_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] BOT  = ~TOP;

    logic signed [ACC_W-1:0]  biased;
    logic signed [ACC_W-1:0]  q;
    logic signed [CORR_W-1:0] corr_c;

    always_comb begin
        biased = in_acc + HALF;
        q      = biased >>> FRAC_W;
        clip_o = CLIP_NONE;
        corr_c = q[CORR_W-1:0];
        if (q > TOP) begin
            clip_o = CLIP_HIGH;
            corr_c = TOP[CORR_W-1:0];
        end else if (q < BOT) begin
            clip_o = CLIP_LOW;
            corr_c = BOT[CORR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v <= 1'b0;
        end else if (adv) begin
            out_v <= in_v;
        end
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            out_code <= in_code;
            out_corr <= corr_c;
        end
    end

endmodule

// File: rtl/inl_cubic_corr.sv
module inl_cubic_corr
    import inl_corr_pkg::*;
#(
    parameter int unsigned CODE_W = DEF_CODE_W,
    parameter int unsigned COEF_W = DEF_COEF_W,
    parameter int unsigned FRAC_W = DEF_FRAC_W,
    parameter int unsigned CORR_W = DEF_CORR_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_sel,
    input  logic [COEF_W-1:0]        cfg_data,
    input  logic                     cfg_commit,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [CODE_W-1:0]        in_code,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [CODE_W-1:0]        out_code,
    output logic signed [CORR_W-1:0] out_corr,
    output logic                     ovf_sticky
);

    localparam int unsigned ACC_W = acc_width(COEF_W);
    localparam int unsigned NST   = NUM_COEF - 1;   // multiply-add stages
    localparam int unsigned EXT_W = ACC_W - COEF_W;

    logic [NUM_COEF-1:0][COEF_W-1:0] act_coef;
    logic                            adv;
    clip_e                           clip_c;

    // Per-boundary pipeline state; index 0 is the input side.
    logic                            sv  [NST+1];
    logic [CODE_W-1:0]               sc  [NST+1];
    logic signed [ACC_W-1:0]         sa  [NST+1];
    logic [NUM_COEF-1:0][COEF_W-1:0] sco [NST+1];

    inl_coef_bank #(
        .COEF_W (COEF_W)
    ) bank_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_data),
        .commit  (cfg_commit),
        .active  (act_coef)
    );

    // One enable moves the whole pipeline; it stalls only when the
    // output register holds a result nobody has taken.
    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;

    assign sv[0]  = in_valid;
    assign sc[0]  = in_code;
    assign sa[0]  = {{EXT_W{act_coef[NUM_COEF-1][COEF_W-1]}}, act_coef[NUM_COEF-1]};
    assign sco[0] = act_coef;

    for (genvar g = 0; g < NST; g++) begin : g_stage
        inl_horner_stage #(
            .CODE_W (CODE_W),
            .COEF_W (COEF_W),
            .ACC_W  (ACC_W),
            .KIDX   (NST - 1 - g)
        ) stage_i (
            .clk      (clk),
            .rst      (rst),
            .adv      (adv),
            .in_v     (sv[g]),
            .in_code  (sc[g]),
            .in_acc   (sa[g]),
            .in_co    (sco[g]),
            .out_v    (sv[g+1]),
            .out_code (sc[g+1]),
            .out_acc  (sa[g+1]),
            .out_co   (sco[g+1])
        );
    end

    inl_round_sat #(
        .CODE_W (CODE_W),
        .ACC_W  (ACC_W),
        .FRAC_W (FRAC_W),
        .CORR_W (CORR_W)
    ) rsat_i (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .in_v     (sv[NST]),
        .in_code  (sc[NST]),
        .in_acc   (sa[NST]),
        .out_v    (out_valid),
        .out_code (out_code),
        .out_corr (out_corr),
        .clip_o   (clip_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_sticky <= 1'b0;
        end else if (adv && sv[NST] && (clip_c != CLIP_NONE)) begin
            ovf_sticky <= 1'b1;
        end
    end

endmodule

// File: rtl/inl_cubic_corr_chk.sv
module inl_cubic_corr_chk
    import inl_corr_pkg::*;
#(
    parameter int unsigned CODE_W = DEF_CODE_W,
    parameter int unsigned COEF_W = DEF_COEF_W,
    parameter int unsigned CORR_W = DEF_CORR_W
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            in_ready,
    input logic                            out_valid,
    input logic                            out_ready,
    input logic [CODE_W-1:0]               out_code,
    input logic signed [CORR_W-1:0]        out_corr,
    input logic                            ovf_sticky,
    input logic                            cfg_commit,
    input logic [NUM_COEF-1:0][COEF_W-1:0] act,
    input logic                            tail_v,
    input logic [NUM_COEF-1:0][COEF_W-1:0] tail_co
);

    // R1: reset leaves the output side empty and the flag clear
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!out_valid && !ovf_sticky));

    // R5: the overflow flag never drops outside reset
    a_r5_sticky_holds: assert property (@(posedge clk) disable iff (rst)
        ovf_sticky |=> ovf_sticky);

    // R8: a refused result is held unchanged
    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_corr) && $stable(out_code)));

    // R8: no new code is taken while the output is refused
    a_r8_no_accept_stalled: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R7: an empty output register never blocks the input
    a_r7_free_when_empty: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    // R9: the active set changes only on a commit
    a_r9_active_held: assert property (@(posedge clk) disable iff (rst)
        !cfg_commit |=> $stable(act));

    // R10: a sample's carried coefficient set stays put while it waits
    a_r10_tail_frozen: assert property (@(posedge clk) disable iff (rst)
        (tail_v && out_valid && !out_ready) |=> $stable(tail_co));

endmodule

bind inl_cubic_corr inl_cubic_corr_chk #(
    .CODE_W (CODE_W),
    .COEF_W (COEF_W),
    .CORR_W (CORR_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_code   (out_code),
    .out_corr   (out_corr),
    .ovf_sticky (ovf_sticky),
    .cfg_commit (cfg_commit),
    .act        (act_coef),
    .tail_v     (sv[NST]),
    .tail_co    (sco[NST])
);

// File: tb/inl_cubic_corr_tb_top.sv
module inl_cubic_corr_tb_top;

    localparam int CODE_W = 14;
    localparam int COEF_W = 18;
    localparam int FRAC_W = 8;
    localparam int CORR_W = 6;
    localparam int STEP   = 1 << FRAC_W;
    localparam int WDOG   = 100000;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     cfg_we = 1'b0;
    logic [1:0]               cfg_sel = '0;
    logic [COEF_W-1:0]        cfg_data = '0;
    logic                     cfg_commit = 1'b0;
    logic                     in_valid = 1'b0;
    logic                     in_ready;
    logic [CODE_W-1:0]        in_code = '0;
    logic                     out_valid;
    logic                     out_ready = 1'b1;
    logic [CODE_W-1:0]        out_code;
    logic signed [CORR_W-1:0] out_corr;
    logic                     ovf_sticky;

    int    total = 0;
    int    bad   = 0;
    int    cyc   = 0;
    bit    done  = 0;
    string tag   = "R1";

    longint shd_m [4];
    longint act_m [4];
    bit     ovf_m = 0;
    int     exp_corr_q [$];
    int     exp_code_q [$];

    always #5 clk = ~clk;

    inl_cubic_corr dut_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_data   (cfg_data),
        .cfg_commit (cfg_commit),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_code    (in_code),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_code   (out_code),
        .out_corr   (out_corr),
        .ovf_sticky (ovf_sticky)
    );

    // Unclamped rounded value from the arithmetic rules in R2 and R3.
    function automatic longint eval_q(input longint xc, input longint b [4]);
        longint acc;
        acc = b[3];
        for (int k = 2; k >= 0; k--) begin
            acc = ((acc * xc) >>> CODE_W) + b[k];
        end
        return (acc + (longint'(1) << (FRAC_W - 1))) >>> FRAC_W;
    endfunction

    function automatic int clamp6(input longint q);
        if (q > 31) return 31;
        if (q < -32) return -32;
        return int'(q);
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Reference model and scoreboard, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst) begin
            for (int k = 0; k < 4; k++) begin
                shd_m[k] = 0;
                act_m[k] = 0;
            end
            ovf_m = 0;
            exp_corr_q.delete();
            exp_code_q.delete();
        end else begin
            if (in_valid && in_ready) begin
                longint q;
                q = eval_q(longint'(in_code), act_m);
                if (q > 31 || q < -32) ovf_m = 1;
                exp_corr_q.push_back(clamp6(q));
                exp_code_q.push_back(int'(in_code));
            end
            if (out_valid && out_ready) begin
                if (exp_corr_q.size() == 0) begin
                    check(0, tag, "unexpected output", longint'(out_code), -1);
                end else begin
                    int ec, ed;
                    ec = exp_corr_q.pop_front();
                    ed = exp_code_q.pop_front();
                    check(int'(out_corr) == ec, tag, "out_corr", longint'(out_corr), ec);
                    check(int'(out_code) == ed, tag, "out_code", longint'(out_code), ed);
                end
            end
            if (cfg_commit) begin
                for (int k = 0; k < 4; k++) act_m[k] = shd_m[k];
            end
            if (cfg_we) shd_m[cfg_sel] = longint'($signed(cfg_data));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !done) begin
            done = 1;
            check(0, "WDOG", "watchdog expired", cyc, WDOG);
            finish_run();
        end
    end

    // All tasks start and end just after a rising edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        cfg_we = 1'b0;
        cfg_commit = 1'b0;
        out_ready = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic cfg_write(input int sel, input longint val);
        cfg_we = 1'b1;
        cfg_sel = 2'(sel);
        cfg_data = COEF_W'(val);
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic cfg_pulse_commit();
        cfg_commit = 1'b1;
        tick();
        cfg_commit = 1'b0;
    endtask

    task automatic load_set(input longint b0, input longint b1,
                            input longint b2, input longint b3);
        cfg_write(0, b0);
        cfg_write(1, b1);
        cfg_write(2, b2);
        cfg_write(3, b3);
        cfg_pulse_commit();
    endtask

    // Present one code and hold it until accepted; in_valid stays high.
    task automatic send(input int x);
        int guard;
        in_valid = 1'b1;
        in_code = CODE_W'(x);
        guard = 0;
        forever begin
            @(negedge clk);
            if (in_ready) break;
            guard++;
            if (guard > 1000) break;
        end
        tick();
    endtask

    task automatic drain();
        int guard;
        in_valid = 1'b0;
        guard = 0;
        while ((exp_corr_q.size() != 0) && guard < 1000) begin
            tick();
            guard++;
        end
        tick();
        check(exp_corr_q.size() == 0, tag, "pending results after drain",
              exp_corr_q.size(), 0);
    endtask

    task automatic t_reset();
        tag = "R1";
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(ovf_sticky == 1'b0, "R1", "ovf_sticky after reset", ovf_sticky, 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        tick();
        send(0);
        send(16383);
        send(5000);
        drain();
    endtask

    task automatic t_rounding();
        longint vals [6] = '{128, -128, 127, -129, 384, -385};
        tag = "R3";
        foreach (vals[i]) begin
            load_set(vals[i], 0, 0, 0);
            send(1234);
        end
        drain();
        load_set(128, 0, 0, 0);
        send(0);
        in_valid = 1'b0;
        repeat (3) tick();
        @(negedge clk);
        check(out_valid && out_corr == 6'sd1, "R3", "tie +0.5 rounds up", out_corr, 1);
        tick();
        drain();
    endtask

    task automatic t_poly();
        int lfsr;
        int ends [4] = '{0, 1, 8192, 16383};
        tag = "R2";
        load_set(0, 20 * STEP, 0, 0);
        foreach (ends[i]) send(ends[i]);
        load_set(0, 0, -25 * STEP + 77, 0);
        foreach (ends[i]) send(ends[i]);
        load_set(0, 0, 0, 29 * STEP - 3);
        foreach (ends[i]) send(ends[i]);
        load_set(-3 * STEP + 17, 40 * STEP + 5, -60 * STEP - 99, 30 * STEP + 200);
        lfsr = 16'hACE1;
        for (int i = 0; i < 40; i++) begin
            lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
            send(lfsr & 16'h3FFF);
        end
        foreach (ends[i]) send(ends[i]);
        drain();
        tag = "R5";
        @(negedge clk);
        check(ovf_sticky == bit'(ovf_m), "R5", "ovf_sticky after cubic set", ovf_sticky, ovf_m);
        tick();
    endtask

    task automatic t_latency();
        int n;
        tag = "R6";
        load_set(5 * STEP, 0, 0, 0);
        in_valid = 1'b1;
        in_code = 14'd777;
        @(negedge clk);
        check(in_ready == 1'b1, "R6", "in_ready before accept", in_ready, 1);
        tick();
        in_valid = 1'b0;
        n = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (out_valid) break;
            n++;
        end
        check(n == 3, "R6", "edges from accept to output", n, 3);
        check(out_code == 14'd777, "R6", "code travels with correction", out_code, 777);
        tick();
        drain();
    endtask

    task automatic t_fullrate();
        int stalls;
        tag = "R7";
        load_set(2 * STEP, -7 * STEP, 11 * STEP, 3 * STEP);
        stalls = 0;
        in_valid = 1'b1;
        for (int i = 0; i < 64; i++) begin
            in_code = CODE_W'(i * 251 + 3);
            @(negedge clk);
            if (!in_ready) stalls++;
            tick();
        end
        drain();
        check(stalls == 0, "R7", "input stalls at full rate", stalls, 0);
    endtask

    task automatic t_backpressure();
        logic signed [CORR_W-1:0] held;
        logic [CODE_W-1:0]        held_code;
        tag = "R8";
        load_set(-9 * STEP, 33 * STEP, -12 * STEP, 17 * STEP);
        out_ready = 1'b0;
        for (int i = 0; i < 4; i++) send(1000 + i * 3001);
        in_valid = 1'b1;
        in_code = 14'd99;
        @(negedge clk);
        check(in_ready == 1'b0, "R8", "in_ready while refused", in_ready, 0);
        held = out_corr;
        held_code = out_code;
        repeat (5) tick();
        @(negedge clk);
        check(out_corr == held, "R8", "out_corr held", out_corr, held);
        check(out_code == held_code, "R8", "out_code held", out_code, held_code);
        tick();
        out_ready = 1'b1;
        send(99);
        drain();
    endtask

    task automatic t_shadow();
        tag = "R9";
        load_set(3 * STEP, 0, 0, 0);
        cfg_write(0, 20 * STEP);
        cfg_write(3, -100 * STEP);
        send(9000);
        drain();
        tag = "R10";
        cfg_pulse_commit();
        send(9000);
        drain();
    endtask

    task automatic t_commit_inflight();
        tag = "R10";
        load_set(1 * STEP, 4 * STEP, 0, 0);
        cfg_write(0, -10 * STEP);
        cfg_write(1, 25 * STEP);
        in_valid = 1'b1;
        for (int i = 0; i < 8; i++) begin
            in_code = CODE_W'(2000 * i + 100);
            cfg_commit = (i == 3);
            tick();
        end
        cfg_commit = 1'b0;
        drain();
    endtask

    task automatic t_write_commit();
        tag = "R11";
        load_set(0, 0, 0, 0);
        cfg_write(0, 6 * STEP);
        cfg_we = 1'b1;
        cfg_sel = 2'd0;
        cfg_data = COEF_W'(-13 * STEP);
        cfg_commit = 1'b1;
        tick();
        cfg_we = 1'b0;
        cfg_commit = 1'b0;
        send(42);
        drain();
        cfg_pulse_commit();
        send(42);
        drain();
    endtask

    task automatic t_saturate();
        tag = "R4";
        do_reset();
        load_set(31 * STEP, 0, 0, 0);
        send(10);
        load_set(-32 * STEP, 0, 0, 0);
        send(10);
        drain();
        @(negedge clk);
        check(ovf_sticky == 1'b0, "R5", "exact limits leave flag clear", ovf_sticky, 0);
        tick();
        load_set(40 * STEP, 0, 0, 0);
        send(10);
        load_set(-50 * STEP, 0, 0, 0);
        send(10);
        load_set(0, 0, 0, 100 * STEP);
        send(16383);
        drain();
        @(negedge clk);
        check(ovf_sticky == 1'b1, "R5", "flag after clamp", ovf_sticky, 1);
        tick();
        load_set(0, 0, 0, 0);
        send(5);
        drain();
        @(negedge clk);
        check(ovf_sticky == 1'b1, "R5", "flag stays set", ovf_sticky, 1);
        tick();
    endtask

    initial begin
        do_reset();
        t_reset();
        t_rounding();
        t_poly();
        t_latency();
        t_fullrate();
        t_backpressure();
        t_shadow();
        t_commit_inflight();
        t_write_commit();
        t_saturate();
        done = 1;
        finish_run();
    end

endmodule